// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends data words over a half-duplex synchronous serial link. An external master supplies the shift clock, and the block never drives that line. The host writes words through a one-cycle write strobe. A write lands in a holding register, or goes straight into the shift register when that register is idle. The shift register presents one bit at a time on the data pin, least-significant bit first. It advances on each falling edge of the external clock, so the master samples on the rising edge.

The external clock passes through a synchronizer and has its edges detected in the system clock domain. The system clock must run at least four times faster than the external clock. The block shows a "holding register empty" flag. An optional interrupt request is formed from that flag without any clocked logic, so it can wake a sleeping system. Words are 8 bits, or 9 bits when the nine-bit mode is set. The ninth bit is captured from a separate input at the moment of the write.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `hold_empty_o` is 1, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: A write while active, with the shift register idle, starts shifting on the next cycle. `sdo_oe_o` goes to 1, bit 0 of the word appears on `sdo_o`, and `hold_empty_o` stays 1.
- R3: Bits leave least-significant first. `sdo_o` moves to the next bit only after a falling edge of `sclk_i`, and a word of N bits takes exactly N falling edges.
- R4: A write while a word is shifting is queued, and `hold_empty_o` reads 0. On the falling edge that ends the current word, the queued word begins at once with its bit 0, and only then does `hold_empty_o` return to 1.
- R5: `irq_o` is 1 exactly when `hold_empty_o` and `irq_en_i` are both 1.
- R6: With `nine_bit_i` = 1 at the write, the word has 9 bits, and bit 8 is the value of `bit9_i` at the write. With `nine_bit_i` = 0 the word has 8 bits.
- R7: The transmitter is active only when `port_en_i`, `tx_en_i` and `slave_mode_i` are all 1. Writes made while inactive are ignored: `sdo_oe_o` stays 0 and `hold_empty_o` stays 1, also after the transmitter becomes active again.
- R8: `sdo_oe_o` is 0 whenever no word is shifting, including right after the last bit of the last word has been shifted out.
- R9: Dropping `tx_en_i` aborts the word in progress and discards any queued word. By the next cycle `sdo_oe_o` is 0 and `hold_empty_o` is 1.
- R10: Rising edges of `sclk_i` never change `sdo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_en_i | input | 1 | Serial port enable |
| tx_en_i | input | 1 | Transmit enable; clearing it aborts |
| slave_mode_i | input | 1 | 1 selects synchronous slave configuration |
| nine_bit_i | input | 1 | 1 selects 9-bit words |
| bit9_i | input | 1 | Ninth bit, captured at the write |
| irq_en_i | input | 1 | Transmit interrupt enable |
| wr_i | input | 1 | One-cycle write strobe |
| wr_data_i | input | 8 | Low 8 bits of the word |
| sclk_i | input | 1 | External shift clock from the master |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data pin (0 = high impedance) |
| hold_empty_o | output | 1 | Holding register empty flag |
| irq_o | output | 1 | Interrupt/wake request |

## Verification
The words 0x55 and 0xAA swap every bit position between them, so any reversal of bit order or of shift direction shows up. The words 0x01 and 0x80 put a single set bit at either end of the word, which exposes an extra or a missing falling edge. Nine-bit words are sent once with the extra bit at 1 and once at 0, to show it comes from `bit9_i` and not from the data. A lone write is set against two back-to-back writes: only the queued case may clear the flag, and it must hand over with no gap. A third pattern aborts a word with a queued word behind it, and a fourth writes while the port is disabled. These cover the enable gating and the rule that ignored writes leave no trace.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W);

  typedef struct packed {
    logic              len9;
    logic [WORD_W-1:0] bits;
  } tx_word_t;
endpackage

// File: rtl/sts_edge_det.sv
module sts_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= sclk_i;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[SYNC_STAGES-1];
  end

  // prev resets low: no false falling edge out of reset
  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sts_shifter.sv
module sts_shifter
  import sts_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clear_i,
  input  logic     load_i,
  input  tx_word_t load_word_i,
  input  logic     adv_i,
  output logic     busy_o,
  output logic     last_o,
  output logic     bit_o
);
  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              len9_q;
  logic              busy_q;

  assign last_o = (cnt_q == (len9_q ? CNT_W'(WORD_W-1) : CNT_W'(DATA_W-1)));
  assign busy_o = busy_q;
  assign bit_o  = sr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
      len9_q <= 1'b0;
    end else if (clear_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      sr_q   <= load_word_i.bits;
      len9_q <= load_word_i.len9;
      cnt_q  <= '0;
    end else if (adv_i && busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
      end else begin
        sr_q  <= sr_q >> 1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sts_ctrl.sv
module sts_ctrl
  import sts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              nine_bit_i,
  input  logic              bit9_i,
  input  logic              fall_i,
  input  logic              busy_i,
  input  logic              last_i,
  output logic              load_o,
  output tx_word_t          load_word_o,
  output logic              hold_full_o
);
  tx_word_t hold_q, wr_word;
  logic     hold_full_q;
  logic     wr_ok, done, free;

  assign wr_word.len9 = nine_bit_i;
  assign wr_word.bits = {nine_bit_i & bit9_i, wr_data_i};

  assign wr_ok = wr_i & active_i;
  assign done  = busy_i & fall_i & last_i;
  assign free  = ~busy_i | done;

  // queued word wins over a fresh write when the shifter frees up
  assign load_o      = active_i & free & (hold_full_q | wr_ok);
  assign load_word_o = hold_full_q ? hold_q : wr_word;
  assign hold_full_o = hold_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else if (!active_i) begin
      hold_full_q <= 1'b0;
    end else if (free) begin
      if (hold_full_q) begin
        hold_full_q <= wr_ok;
        if (wr_ok) hold_q <= wr_word;
      end
    end else if (wr_ok) begin
      hold_full_q <= 1'b1;
      hold_q      <= wr_word;
    end
  end
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sts_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic              tx_en_i,
  input  logic              slave_mode_i,
  input  logic              nine_bit_i,
  input  logic              bit9_i,
  input  logic              irq_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sclk_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              hold_empty_o,
  output logic              irq_o
);
  logic     active, sclk_fall, busy, last, load, hold_full, shift_bit;
  tx_word_t load_word;

  assign active = port_en_i & tx_en_i & slave_mode_i;

  sts_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .fall_o (sclk_fall)
  );

  sts_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .wr_i        (wr_i),
    .wr_data_i   (wr_data_i),
    .nine_bit_i  (nine_bit_i),
    .bit9_i      (bit9_i),
    .fall_i      (sclk_fall),
    .busy_i      (busy),
    .last_i      (last),
    .load_o      (load),
    .load_word_o (load_word),
    .hold_full_o (hold_full)
  );

  sts_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (~active),
    .load_i      (load),
    .load_word_i (load_word),
    .adv_i       (sclk_fall),
    .busy_o      (busy),
    .last_o      (last),
    .bit_o       (shift_bit)
  );

  assign sdo_oe_o     = busy;
  assign sdo_o        = busy & shift_bit;
  assign hold_empty_o = ~hold_full;
  // combinational so it can wake a system whose clock is stopped
  assign irq_o        = ~hold_full & irq_en_i;
endmodule

// File: rtl/sync_slave_tx_chk.sv
module sync_slave_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic port_en_i,
  input logic tx_en_i,
  input logic slave_mode_i,
  input logic wr_i,
  input logic fall_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic hold_empty_o
);
  logic act;
  assign act = port_en_i & tx_en_i & slave_mode_i;

  p_inactive_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> !sdo_oe_o);

  p_abort_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> hold_empty_o);

  p_idle_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && wr_i && !sdo_oe_o && hold_empty_o) |=> (sdo_oe_o && hold_empty_o));

  p_queue_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && wr_i && sdo_oe_o && !fall_i) |=> !hold_empty_o);

  p_bit_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$past(fall_i)) |-> $stable(sdo_o));
endmodule

bind sync_slave_tx sync_slave_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .port_en_i    (port_en_i),
  .tx_en_i      (tx_en_i),
  .slave_mode_i (slave_mode_i),
  .wr_i         (wr_i),
  .fall_i       (sclk_fall),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o),
  .hold_empty_o (hold_empty_o)
);

// File: tb/sync_slave_tx_test.sv
`timescale 1ns/1ps
module sync_slave_tx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 0, tx_en = 0, slave_mode = 0, nine_bit = 0, bit9 = 0, irq_en = 0;
  logic wr = 0, sclk = 0;
  logic [7:0] wr_data = '0;
  logic sdo, sdo_oe, hold_empty, irq;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic rise_moved;

  always #2.5 clk = ~clk;

  sync_slave_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .tx_en_i(tx_en),
    .slave_mode_i(slave_mode), .nine_bit_i(nine_bit), .bit9_i(bit9),
    .irq_en_i(irq_en), .wr_i(wr), .wr_data_i(wr_data), .sclk_i(sclk),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .hold_empty_o(hold_empty), .irq_o(irq)
  );

  // {nine_bit, bit9, data}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'h55}, {2'b00, 8'hAA}, {2'b00, 8'h01},
    {2'b00, 8'h80}, {2'b11, 8'h3C}, {2'b10, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic nb, input logic b9, input logic [7:0] d);
    @(negedge clk);
    nine_bit = nb; bit9 = b9; wr_data = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  // receive n bits; sample while sclk low, check stability over rising edge
  task automatic recv(input int n, output logic [8:0] w);
    w = '0;
    rise_moved = 0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = sdo;
      w[i] = b;
      sclk = 1; wait_clk(6);
      if (sdo !== b) rise_moved = 1;
      sclk = 0; wait_clk(6);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] got, exp;
    wait_clk(3);
    chk(hold_empty === 1 && sdo_oe === 0 && sdo === 0, "R1 reset", {6'd0, hold_empty, sdo_oe, sdo}, 9'b100);
    rst_n = 1;
    wait_clk(2);
    port_en = 1; tx_en = 1; slave_mode = 1;
    wait_clk(2);

    // table walk: lone words, various patterns
    for (int k = 0; k < 6; k++) begin
      int n;
      n = VEC[k][9] ? 9 : 8;
      exp = VEC[k][9] ? {VEC[k][8], VEC[k][7:0]} : {1'b0, VEC[k][7:0]};
      write(VEC[k][9], VEC[k][8], VEC[k][7:0]);
      wait_clk(1);
      chk(sdo_oe === 1 && hold_empty === 1, "R2 idle write starts", {7'd0, sdo_oe, hold_empty}, 9'b11);
      recv(n, got);
      chk(got === exp, VEC[k][9] ? "R6 nine-bit word" : "R3 lsb-first word", got, exp);
      chk(rise_moved === 0, "R10 rising edge no change", {8'd0, rise_moved}, 9'd0);
      chk(sdo_oe === 0, "R8 oe off after last bit", {8'd0, sdo_oe}, 9'd0);
    end

    // R5 irq with flag
    irq_en = 0; wait_clk(1);
    chk(irq === 0, "R5 irq masked", {8'd0, irq}, 9'd0);
    irq_en = 1; wait_clk(1);
    chk(irq === 1, "R5 irq on empty", {8'd0, irq}, 9'd1);

    // R4 queued word
    write(0, 0, 8'hC3);
    write(0, 0, 8'h5A);
    wait_clk(1);
    chk(hold_empty === 0, "R4 flag clear when queued", {8'd0, hold_empty}, 9'd0);
    chk(irq === 0, "R5 irq low when queued", {8'd0, irq}, 9'd0);
    recv(8, got);
    chk(got === 9'h0C3, "R4 first word", got, 9'h0C3);
    chk(sdo_oe === 1 && hold_empty === 1 && irq === 1, "R4 handover flag", {6'd0, sdo_oe, hold_empty, irq}, 9'b111);
    recv(8, got);
    chk(got === 9'h05A, "R4 queued word", got, 9'h05A);
    chk(sdo_oe === 0, "R8 oe off after queue", {8'd0, sdo_oe}, 9'd0);

    // R9 abort
    write(0, 0, 8'hF0);
    write(0, 0, 8'h0F);
    recv(3, got);
    tx_en = 0; wait_clk(2);
    chk(sdo_oe === 0 && hold_empty === 1, "R9 abort clears", {7'd0, sdo_oe, hold_empty}, 9'b01);
    tx_en = 1; wait_clk(4);
    chk(sdo_oe === 0 && hold_empty === 1, "R9 queued word discarded", {7'd0, sdo_oe, hold_empty}, 9'b01);

    // R7 writes ignored when inactive
    port_en = 0;
    write(0, 0, 8'h99); wait_clk(2);
    chk(sdo_oe === 0 && hold_empty === 1, "R7 port disabled write", {7'd0, sdo_oe, hold_empty}, 9'b01);
    port_en = 1; slave_mode = 0;
    write(0, 0, 8'h99); wait_clk(2);
    chk(sdo_oe === 0 && hold_empty === 1, "R7 not slave write", {7'd0, sdo_oe, hold_empty}, 9'b01);
    slave_mode = 1; wait_clk(4);
    chk(sdo_oe === 0 && hold_empty === 1, "R7 nothing after reenable", {7'd0, sdo_oe, hold_empty}, 9'b01);

    // R6 ninth bit low in 9-bit mode, after re-enable
    write(1, 0, 8'hFF);
    wait_clk(1);
    recv(9, got);
    chk(got === 9'h0FF, "R6 ninth bit zero", got, 9'h0FF);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule